// File: doc/BRIEF.md
# Parameterised Register Field Cell

This block holds one field of a control and status register. Software reaches it through a one-cycle request strobe with a write flag and write data. Hardware reaches it through a next-value bus and an enable whose polarity is chosen by a parameter. The field drives its stored value, a one-cycle access strobe, a one-cycle modify strobe and an interrupt line toward the surrounding logic. Address decoding and bus handling belong to the register block that contains many of these cells.

Parameters select the flavour of the field. A plain field is written by software or hardware. A single-pulse field turns each software write into a value that lasts one cycle and then clears itself. An interrupt field collects hardware events in one of two ways. In level form, each high input bit sets the matching stored bit. In sticky form, the first nonzero input word is captured and held. Any software access clears an interrupt field.

Top module: `reg_field_cell`

## Requirements
- R1: After reset is released, the value is zero and the access strobe, modify strobe and interrupt are low.
- R2: In plain mode a software write (request high, write flag high) makes the value equal the write data from the next clock edge on, and a software read (request high, write flag low) leaves the value unchanged.
- R3: In plain mode, when a software write and an active hardware enable occur in the same cycle, the software write data is stored and the hardware value is dropped.
- R4: With the enable active-high, a plain field loads the hardware next value on the clock edge at which the enable is 1, and holds its value while the enable is 0.
- R5: With the enable active-low, a plain field loads the hardware next value on the clock edge at which the enable is 0, and holds its value while the enable is 1.
- R6: In single-pulse mode a software write shows its data on the value for exactly one cycle, after which the value returns to zero unless another write follows; reads and the hardware inputs never change the value.
- R7: The access strobe is high in exactly the cycle after each software request (read or write) and low otherwise.
- R8: The modify strobe is high in the cycle after a software request that changed the stored value (a write of data different from the current value, or an access that clears a nonzero interrupt field) and low otherwise.
- R9: In level interrupt mode each cycle ORs the hardware next value into the stored value, so a bit that was high for one cycle stays set after the input drops.
- R10: In sticky interrupt mode, a zero field captures the first nonzero hardware next value, and later hardware values are ignored while the field is nonzero.
- R11: In both interrupt modes any software access clears the field to zero at the next edge, even if hardware sets bits in the same cycle.
- R12: The interrupt output is high exactly when at least one bit of the value is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_req | input | 1 | One-cycle software access request |
| sw_wr | input | 1 | 1 for a write, 0 for a read, valid with sw_req |
| sw_wdata | input | WIDTH | Software write data |
| hw_next | input | WIDTH | Hardware next value or event bits |
| hw_en | input | 1 | Hardware enable, polarity set by EN_ACTIVE_LOW |
| value | output | WIDTH | Stored field value |
| sw_acc_pulse | output | 1 | Software access strobe |
| sw_mod_pulse | output | 1 | Software modify strobe |
| irq | output | 1 | OR of all value bits |

## Verification
The assertions take for granted that sw_wr and sw_wdata are only meaningful while sw_req is high, and that hardware inputs are known on each clock edge once reset is released. They do not assume that software and hardware avoid each other, so same-cycle conflicts fall inside what they cover. The stimulus drives every input on the falling edge with defined values, including deliberate same-cycle collisions and writes of unchanged data. Five instances, one per flavour, share the same stimulus and are each checked against their own behavioural model.

// File: rtl/reg_field_pkg.sv
// Shared types for the register field cell.
// Assumes nothing beyond a SystemVerilog 2017 compiler.
package reg_field_pkg;

    // Interrupt capture flavour of a field
    typedef enum logic [1:0] {
        INTR_OFF    = 2'd0,
        INTR_LEVEL  = 2'd1,
        INTR_STICKY = 2'd2
    } intr_mode_e;

endpackage

// File: rtl/field_next_sel.sv
// Next-state selection for one field: picks the value the storage takes at
// the next edge and reports whether software caused a change.
// Assumes sw_wr and sw_wdata matter only while sw_req is high.
module field_next_sel
    import reg_field_pkg::*;
#(
    parameter int         WIDTH         = 8,
    parameter bit         SELF_CLEAR    = 1'b0,
    parameter bit         EN_ACTIVE_LOW = 1'b0,
    parameter intr_mode_e INTR_MODE     = INTR_OFF
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             sw_req,
    input  logic             sw_wr,
    input  logic [WIDTH-1:0] sw_wdata,
    input  logic [WIDTH-1:0] hw_next,
    input  logic             hw_en,
    output logic [WIDTH-1:0] nxt,
    output logic             sw_changed
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic sw_write;
    logic hw_load;

    // Decode the software write and the polarity-corrected hardware enable
    always_comb begin
        sw_write = sw_req & sw_wr;
        hw_load  = EN_ACTIVE_LOW ? ~hw_en : hw_en;
    end

    generate
        if (INTR_MODE == INTR_LEVEL) begin : g_level
            // Level capture: OR in events, any software access clears
            always_comb begin
                nxt        = sw_req ? ZERO : (cur | hw_next);
                sw_changed = sw_req & (cur != ZERO);
            end
        end else if (INTR_MODE == INTR_STICKY) begin : g_sticky
            // Sticky capture: keep first nonzero word, any access clears
            always_comb begin
                if (sw_req)
                    nxt = ZERO;
                else if (cur == ZERO)
                    nxt = hw_next;
                else
                    nxt = cur;
                sw_changed = sw_req & (cur != ZERO);
            end
        end else if (SELF_CLEAR) begin : g_pulse
            // Single pulse: written data lives one cycle, hardware ignored
            always_comb begin
                nxt        = sw_write ? sw_wdata : ZERO;
                sw_changed = sw_write & (sw_wdata != cur);
            end
        end else begin : g_plain
            // Plain storage: software write first, then hardware load
            always_comb begin
                if (sw_write)
                    nxt = sw_wdata;
                else if (hw_load)
                    nxt = hw_next;
                else
                    nxt = cur;
                sw_changed = sw_write & (sw_wdata != cur);
            end
        end
    endgenerate

endmodule

// File: rtl/field_store.sv
// Storage flops for one field with synchronous active-low reset to zero.
// Assumes the next value is settled before each rising edge.
module field_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    // Register the selected next value
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/field_strobe_gen.sv
// Registers the software access and modify strobes so that each lasts one
// cycle and lines up with the edge at which the value is updated.
// Assumes sw_req is a single-cycle request per access.
module field_strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic sw_changed,
    output logic acc_pulse,
    output logic mod_pulse
);

    // Capture access and modify events for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_pulse <= 1'b0;
            mod_pulse <= 1'b0;
        end else begin
            acc_pulse <= sw_req;
            mod_pulse <= sw_req & sw_changed;
        end
    end

endmodule

// File: rtl/reg_field_cell.sv
// One register field with parameter-selected behaviour: plain, single-pulse
// or interrupt capture (level or sticky), with access and modify strobes.
// Assumes a synchronous active-low reset and one request per access.
module reg_field_cell
    import reg_field_pkg::*;
#(
    parameter int         WIDTH         = 8,
    parameter bit         SELF_CLEAR    = 1'b0,
    parameter bit         EN_ACTIVE_LOW = 1'b0,
    parameter intr_mode_e INTR_MODE     = INTR_OFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic             sw_wr,
    input  logic [WIDTH-1:0] sw_wdata,
    input  logic [WIDTH-1:0] hw_next,
    input  logic             hw_en,
    output logic [WIDTH-1:0] value,
    output logic             sw_acc_pulse,
    output logic             sw_mod_pulse,
    output logic             irq
);

    logic [WIDTH-1:0] nxt;
    logic             sw_changed;

    field_next_sel #(
        .WIDTH         (WIDTH),
        .SELF_CLEAR    (SELF_CLEAR),
        .EN_ACTIVE_LOW (EN_ACTIVE_LOW),
        .INTR_MODE     (INTR_MODE)
    ) next_i (
        .cur        (value),
        .sw_req     (sw_req),
        .sw_wr      (sw_wr),
        .sw_wdata   (sw_wdata),
        .hw_next    (hw_next),
        .hw_en      (hw_en),
        .nxt        (nxt),
        .sw_changed (sw_changed)
    );

    field_store #(
        .WIDTH (WIDTH)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .q     (value)
    );

    field_strobe_gen strobe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_req     (sw_req),
        .sw_changed (sw_changed),
        .acc_pulse  (sw_acc_pulse),
        .mod_pulse  (sw_mod_pulse)
    );

    // Interrupt line follows any set bit of the stored value
    always_comb begin
        irq = |value;
    end

endmodule

// File: rtl/reg_field_cell_chk.sv
// Assertion checker for reg_field_cell, attached with bind below.
// Assumes inputs are known at every edge after reset is released.
module reg_field_cell_chk
    import reg_field_pkg::*;
#(
    parameter int         WIDTH         = 8,
    parameter bit         SELF_CLEAR    = 1'b0,
    parameter bit         EN_ACTIVE_LOW = 1'b0,
    parameter intr_mode_e INTR_MODE     = INTR_OFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_req,
    input logic             sw_wr,
    input logic [WIDTH-1:0] sw_wdata,
    input logic [WIDTH-1:0] hw_next,
    input logic             hw_en,
    input logic [WIDTH-1:0] value,
    input logic             sw_acc_pulse,
    input logic             sw_mod_pulse,
    input logic             irq
);

    localparam bit IS_PLAIN = (INTR_MODE == INTR_OFF) && !SELF_CLEAR;
    localparam bit IS_PULSE = (INTR_MODE == INTR_OFF) && SELF_CLEAR;
    localparam bit IS_INTR  = (INTR_MODE != INTR_OFF);

    logic en_act;
    always_comb en_act = EN_ACTIVE_LOW ? !hw_en : hw_en;

    AST_ACC_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> sw_acc_pulse); // R7
    AST_NO_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_req |=> !sw_acc_pulse); // R7
    AST_MOD_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mod_pulse |-> sw_acc_pulse); // R8
    AST_IRQ_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (value != '0) |-> irq); // R12
    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PLAIN && sw_req && sw_wr) |=> (value == $past(sw_wdata))); // R3
    AST_HW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PLAIN && !(sw_req && sw_wr) && en_act) |=> (value == $past(hw_next))); // R4
    AST_HW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PLAIN && !sw_req && !en_act) |=> $stable(value)); // R5
    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PULSE && !(sw_req && sw_wr)) |=> (value == '0)); // R6
    AST_LEVEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (INTR_MODE == INTR_LEVEL && !sw_req) |=> ((value & $past(value)) == $past(value))); // R9
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (INTR_MODE == INTR_STICKY && !sw_req && value != '0) |=> $stable(value)); // R10
    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_INTR && sw_req) |=> (value == '0)); // R11

endmodule

bind reg_field_cell reg_field_cell_chk #(
    .WIDTH         (WIDTH),
    .SELF_CLEAR    (SELF_CLEAR),
    .EN_ACTIVE_LOW (EN_ACTIVE_LOW),
    .INTR_MODE     (INTR_MODE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_req       (sw_req),
    .sw_wr        (sw_wr),
    .sw_wdata     (sw_wdata),
    .hw_next      (hw_next),
    .hw_en        (hw_en),
    .value        (value),
    .sw_acc_pulse (sw_acc_pulse),
    .sw_mod_pulse (sw_mod_pulse),
    .irq          (irq)
);

// File: tb/reg_field_cell_tb_top.sv
// Bench: five field flavours share one stimulus; each is compared every
// cycle against a behavioural model kept in plain arrays.
module reg_field_cell_tb_top;
    import reg_field_pkg::*;

    localparam int W = 8;
    localparam int N = 5;   // 0 plain/high, 1 plain/low, 2 pulse, 3 level, 4 sticky

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_req = 1'b0;
    logic         sw_wr = 1'b0;
    logic [W-1:0] sw_wdata = '0;
    logic [W-1:0] hw_next = '0;
    logic         hw_en = 1'b0;

    logic [W-1:0] val [N];
    logic         acc [N];
    logic         mdf [N];
    logic         irq [N];

    int total = 0;
    int bad = 0;

    int m_q [N];
    int m_acc [N];
    int m_mod [N];
    string vtag [N] = '{"R2 R3 R4", "R5", "R6", "R9 R11", "R10 R11"};

    always #5 clk = ~clk;

    reg_field_cell #(.WIDTH(W), .SELF_CLEAR(1'b0), .EN_ACTIVE_LOW(1'b0), .INTR_MODE(INTR_OFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .hw_next(hw_next), .hw_en(hw_en), .value(val[0]), .sw_acc_pulse(acc[0]),
        .sw_mod_pulse(mdf[0]), .irq(irq[0]));
    reg_field_cell #(.WIDTH(W), .SELF_CLEAR(1'b0), .EN_ACTIVE_LOW(1'b1), .INTR_MODE(INTR_OFF)) dut_low_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .hw_next(hw_next), .hw_en(hw_en), .value(val[1]), .sw_acc_pulse(acc[1]),
        .sw_mod_pulse(mdf[1]), .irq(irq[1]));
    reg_field_cell #(.WIDTH(W), .SELF_CLEAR(1'b1), .EN_ACTIVE_LOW(1'b0), .INTR_MODE(INTR_OFF)) dut_pulse_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .hw_next(hw_next), .hw_en(hw_en), .value(val[2]), .sw_acc_pulse(acc[2]),
        .sw_mod_pulse(mdf[2]), .irq(irq[2]));
    reg_field_cell #(.WIDTH(W), .SELF_CLEAR(1'b0), .EN_ACTIVE_LOW(1'b0), .INTR_MODE(INTR_LEVEL)) dut_level_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .hw_next(hw_next), .hw_en(hw_en), .value(val[3]), .sw_acc_pulse(acc[3]),
        .sw_mod_pulse(mdf[3]), .irq(irq[3]));
    reg_field_cell #(.WIDTH(W), .SELF_CLEAR(1'b0), .EN_ACTIVE_LOW(1'b0), .INTR_MODE(INTR_STICKY)) dut_sticky_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .hw_next(hw_next), .hw_en(hw_en), .value(val[4]), .sw_acc_pulse(acc[4]),
        .sw_mod_pulse(mdf[4]), .irq(irq[4]));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the models by one edge using the inputs now applied
    task automatic model_step();
        int wr_ev = (sw_req && sw_wr) ? 1 : 0;
        int hn = int'(hw_next);
        int wd = int'(sw_wdata);
        for (int k = 0; k < N; k++) begin
            int nq;
            int chg;
            case (k)
                0, 1: begin
                    int en_on = (k == 0) ? int'(hw_en) : int'(!hw_en);
                    nq  = wr_ev ? wd : (en_on ? hn : m_q[k]);
                    chg = wr_ev && (wd != m_q[k]);
                end
                2: begin
                    nq  = wr_ev ? wd : 0;
                    chg = wr_ev && (wd != m_q[k]);
                end
                3: begin
                    nq  = sw_req ? 0 : (m_q[k] | hn);
                    chg = sw_req && (m_q[k] != 0);
                end
                default: begin
                    nq  = sw_req ? 0 : ((m_q[k] == 0) ? hn : m_q[k]);
                    chg = sw_req && (m_q[k] != 0);
                end
            endcase
            m_acc[k] = sw_req ? 1 : 0;
            m_mod[k] = chg ? 1 : 0;
            m_q[k]   = nq;
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < N; k++) begin
            check({"value ", vtag[k]}, int'(val[k]), m_q[k]);
            check("acc strobe R7", int'(acc[k]), m_acc[k]);
            check("mod strobe R8", int'(mdf[k]), m_mod[k]);
            check("irq R12", int'(irq[k]), (m_q[k] != 0) ? 1 : 0);
        end
    endtask

    // One cycle: apply inputs at the falling edge, compare at the next one
    task automatic cyc(input logic rq, input logic wr, input logic [W-1:0] wd,
                       input logic [W-1:0] hn, input logic en);
        sw_req = rq; sw_wr = wr; sw_wdata = wd; hw_next = hn; hw_en = en;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            m_q[k] = 0; m_acc[k] = 0; m_mod[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: everything zero after reset, with idle inputs
        for (int k = 0; k < N; k++) begin
            check("reset value R1", int'(val[k]), 0);
            check("reset strobes R1", int'(acc[k] | mdf[k] | irq[k]), 0);
        end
        cyc(1'b1, 1'b1, 8'hA5, 8'h00, 1'b0);   // write
        check("plain write R2", int'(val[0]), 'hA5);
        check("pulse shows data R6", int'(val[2]), 'hA5);
        cyc(1'b1, 1'b0, 8'h00, 8'h00, 1'b0);   // read
        check("plain read keeps R2", int'(val[0]), 'hA5);
        check("pulse back to zero R6", int'(val[2]), 0);
        cyc(1'b0, 1'b0, 8'h00, 8'h3C, 1'b1);   // enable high
        check("active-high load R4", int'(val[0]), 'h3C);
        check("sticky capture R10", int'(val[4]), 'h3C);
        cyc(1'b0, 1'b0, 8'h00, 8'h81, 1'b0);   // enable low
        check("active-low load R5", int'(val[1]), 'h81);
        check("level keeps bits R9", int'(val[3]), 'hBD);
        check("sticky ignores R10", int'(val[4]), 'h3C);
        cyc(1'b1, 1'b1, 8'h55, 8'hAA, 1'b1);   // collision
        check("software wins R3", int'(val[0]), 'h55);
        check("access clears level R11", int'(val[3]), 0);
        check("access clears sticky R11", int'(val[4]), 0);
        cyc(1'b1, 1'b1, 8'h55, 8'h00, 1'b1);   // same data again
        check("unchanged write no mod R8", int'(mdf[0]), 0);
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
        for (int i = 0; i < 400; i++) begin
            logic rq = ($urandom_range(0, 3) == 0);
            logic [W-1:0] hn = ($urandom_range(0, 2) == 0) ? 8'(1 << $urandom_range(0, 7))
                                                            : 8'($urandom);
            if ($urandom_range(0, 1) == 0) hn = '0;
            cyc(rq, 1'($urandom), 8'($urandom), hn, 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule